// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the results of in-flight instructions in an out-of-order core between the end of execution and retirement. Each accepted dispatch claims the slot at the tail of a circular buffer and gets back that slot's index as its tag. Execution units later write a result into the slot named by the tag. The oldest slot leaves the buffer only once its result is present, so architectural updates happen strictly in program order.

Every slot records what kind of instruction it holds: a register write, a store or a branch. Only a register-write slot drives the register-file write strobe, and only a store slot drives the store-commit strobe. A branch slot that retires with its mispredict flag set raises a redirect carrying the correct PC, and all younger slots are discarded at that same edge. Operand lookup ports let a consumer ask about an architectural register. Each port reports whether a producer of that register is still in the buffer and, for the youngest such producer, gives either its finished value or its tag.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, no lookup port reports busy, and `rf_we`, `st_commit` and `redirect` are 0.
- R2: An accepted dispatch (`disp_valid` and `disp_ready` both high at a clock edge) gets the tag shown on `disp_tag` in that cycle. Consecutive accepted dispatches get consecutive tags, modulo DEPTH (16).
- R3: With DEPTH entries in flight, `disp_ready` is 0 and a dispatch attempt leaves the buffer unchanged. An ignored dispatch to register 31 does not become visible on a lookup.
- R4: A write-back (`wb_valid`, `wb_tag`, `wb_value`) marks that entry complete. Commit takes the oldest entry only, and only when that entry is complete. A younger complete entry waits behind an incomplete head.
- R5: A register-write entry (kind code 0) commits with `rf_we`=1, `rf_waddr` set to its destination, `commit_data` set to its result and `commit_tag` set to its tag. At most one entry commits per cycle.
- R6: A store entry (kind code 1) commits with `st_commit`=1 and `rf_we`=0, and puts its value on `commit_data`. A correctly predicted branch entry (kind code 2) retires with none of `rf_we`, `st_commit` or `redirect` raised.
- R7: When the head is a complete branch whose write-back carried `wb_mispred`=1, `redirect` is 1 and `redirect_pc` equals the branch's written value. `disp_ready` is 0 in that cycle. After the edge the buffer is empty and the next tag is the branch tag plus one.
- R8: A lookup reports `lu_busy`=1 only if a register-write entry with a matching destination is in flight; store and branch entries never count. For the youngest such entry, `lu_ready` shows whether it is complete, `lu_tag` gives its tag, and `lu_value` gives its result when it is complete.
- R9: A write-back to an entry that is being flushed in the same cycle, or to an entry that has already left the buffer, has no effect. A slot that is dispatched into again afterwards is still incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Instruction kind: 0 register write, 1 store, 2 branch |
| disp_dest | input | REG_W | Destination architectural register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | TAG_W | Tag given to the dispatch in this cycle |
| wb_valid | input | 1 | Result write-back strobe |
| wb_tag | input | TAG_W | Entry being written back |
| wb_value | input | DATA_W | Result, or the correct target PC for a branch |
| wb_mispred | input | 1 | Branch resolved against its prediction |
| lu_reg | input | LU_PORTS x REG_W | Source register per lookup port |
| lu_busy | output | LU_PORTS | Youngest producer still in flight |
| lu_ready | output | LU_PORTS | That producer has its result |
| lu_tag | output | LU_PORTS x TAG_W | Tag of that producer |
| lu_value | output | LU_PORTS x DATA_W | Result of that producer when ready, else 0 |
| rf_we | output | 1 | Register file write at commit |
| rf_waddr | output | REG_W | Register file write address |
| commit_data | output | DATA_W | Value of the committing entry |
| st_commit | output | 1 | Store released to memory |
| commit_tag | output | TAG_W | Tag of the head entry |
| redirect | output | 1 | Mispredict redirect with full flush |
| redirect_pc | output | DATA_W | Correct fetch PC on redirect |

## Verification
The buffer is filled to all sixteen slots, and results are written back in reverse age order. This separates in-order retirement from retirement in completion order, and it also exercises the full stall and the wrap of the tag counter. The lookup ports are swept over every architectural register while several writers of one register and a store to the same register are in flight. The sweep shows that the port selects the youngest producer and ignores non-producers, and that it switches from tag to value when the producer completes. A correctly predicted branch and a mispredicted one are retired. In the mispredict case a dispatch and a write-back are driven in the flush cycle, which shows that both are dropped and that a recycled slot starts incomplete.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DEPTH    = 16;
    localparam int ARCH_REG_W   = 5;
    localparam int WORD_W       = 32;
    localparam int LOOKUP_PORTS = 2;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } op_kind_e;

    function automatic logic writes_reg(op_kind_e k);
        return k == KIND_REG;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    // DEPTH must be a power of two so that pointers wrap by width.
    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            head  <= head + TAG_W'(1);
            tail  <= head + TAG_W'(1);
            count <= '0;
        end else begin
            head  <= head + TAG_W'(pop);
            tail  <= tail + TAG_W'(push);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
    parameter int DEPTH  = 16,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic [TAG_W-1:0]             head,
    input  logic [DEPTH-1:0]             ent_valid,
    input  logic [DEPTH-1:0]             ent_ready,
    input  logic [DEPTH-1:0]             ent_prod,
    input  logic [DEPTH-1:0][REG_W-1:0]  ent_dest,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_value,
    input  logic [REG_W-1:0]             src_reg,
    output logic                         busy,
    output logic                         ready,
    output logic [TAG_W-1:0]             tag,
    output logic [DATA_W-1:0]            value
);
    logic [TAG_W-1:0] idx;

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        busy  = 1'b0;
        ready = 1'b0;
        tag   = '0;
        value = '0;
        idx   = head;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + TAG_W'(k);
            if (ent_valid[idx] && ent_prod[idx] && ent_dest[idx] == src_reg) begin
                busy  = 1'b1;
                ready = ent_ready[idx];
                tag   = idx;
                value = ent_ready[idx] ? ent_value[idx] : '0;
            end
        end
    end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              head_valid,
    input  logic              head_ready,
    input  op_kind_e          head_kind,
    input  logic              head_mispred,
    input  logic [REG_W-1:0]  head_dest,
    input  logic [DATA_W-1:0] head_value,
    input  logic [TAG_W-1:0]  head_tag,
    output logic              fire,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] commit_data,
    output logic              st_commit,
    output logic [TAG_W-1:0]  commit_tag,
    output logic              redirect,
    output logic [DATA_W-1:0] redirect_pc
);
    always_comb begin
        fire        = head_valid && head_ready;
        rf_we       = fire && writes_reg(head_kind);
        st_commit   = fire && (head_kind == KIND_STORE);
        redirect    = fire && (head_kind == KIND_BRANCH) && head_mispred;
        rf_waddr    = head_dest;
        commit_data = head_value;
        commit_tag  = head_tag;
        redirect_pc = head_value;
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH    = ROB_DEPTH,
    parameter int REG_W    = ARCH_REG_W,
    parameter int DATA_W   = WORD_W,
    parameter int LU_PORTS = LOOKUP_PORTS,
    localparam int TAG_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               disp_valid,
    input  logic [1:0]                         disp_kind,
    input  logic [REG_W-1:0]                   disp_dest,
    output logic                               disp_ready,
    output logic [TAG_W-1:0]                   disp_tag,
    input  logic                               wb_valid,
    input  logic [TAG_W-1:0]                   wb_tag,
    input  logic [DATA_W-1:0]                  wb_value,
    input  logic                               wb_mispred,
    input  logic [LU_PORTS-1:0][REG_W-1:0]     lu_reg,
    output logic [LU_PORTS-1:0]                lu_busy,
    output logic [LU_PORTS-1:0]                lu_ready,
    output logic [LU_PORTS-1:0][TAG_W-1:0]     lu_tag,
    output logic [LU_PORTS-1:0][DATA_W-1:0]    lu_value,
    output logic                               rf_we,
    output logic [REG_W-1:0]                   rf_waddr,
    output logic [DATA_W-1:0]                  commit_data,
    output logic                               st_commit,
    output logic [TAG_W-1:0]                   commit_tag,
    output logic                               redirect,
    output logic [DATA_W-1:0]                  redirect_pc
);
    typedef struct packed {
        logic              valid;
        op_kind_e          kind;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
        logic              ready;
        logic              mispred;
    } rob_ent_t;

    rob_ent_t ents [DEPTH];

    logic [TAG_W-1:0] head, tail;
    logic [CNT_W-1:0] occ;
    logic             full, push, pop, flush;

    assign disp_ready = !full && !flush;
    assign push       = disp_valid && disp_ready;
    assign disp_tag   = tail;

    rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
        .head(head), .tail(tail), .count(occ), .full(full)
    );

    // Entry storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) ents[i].valid <= 1'b0;
        end else begin
            if (wb_valid && ents[wb_tag].valid) begin
                ents[wb_tag].ready   <= 1'b1;
                ents[wb_tag].value   <= wb_value;
                ents[wb_tag].mispred <= wb_mispred;
            end
            if (pop) ents[head].valid <= 1'b0;
            if (push) begin
                ents[tail].valid   <= 1'b1;
                ents[tail].kind    <= op_kind_e'(disp_kind);
                ents[tail].dest    <= disp_dest;
                ents[tail].value   <= '0;
                ents[tail].ready   <= 1'b0;
                ents[tail].mispred <= 1'b0;
            end
        end
    end

    // Retirement
    rob_ent_t head_e;
    logic     fire;
    assign head_e = ents[head];

    rob_retire #(.REG_W(REG_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_retire (
        .head_valid(head_e.valid), .head_ready(head_e.ready),
        .head_kind(head_e.kind), .head_mispred(head_e.mispred),
        .head_dest(head_e.dest), .head_value(head_e.value), .head_tag(head),
        .fire(fire), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .commit_data(commit_data), .st_commit(st_commit),
        .commit_tag(commit_tag), .redirect(redirect), .redirect_pc(redirect_pc)
    );

    assign pop   = fire;
    assign flush = redirect;

    // Flattened entry fields for the lookup ports
    logic [DEPTH-1:0]             f_valid, f_ready, f_prod;
    logic [DEPTH-1:0][REG_W-1:0]  f_dest;
    logic [DEPTH-1:0][DATA_W-1:0] f_value;

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign f_valid[i] = ents[i].valid;
        assign f_ready[i] = ents[i].ready;
        assign f_prod[i]  = writes_reg(ents[i].kind);
        assign f_dest[i]  = ents[i].dest;
        assign f_value[i] = ents[i].value;
    end

    for (genvar p = 0; p < LU_PORTS; p++) begin : g_lu
        rob_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_lu (
            .head(head), .ent_valid(f_valid), .ent_ready(f_ready), .ent_prod(f_prod),
            .ent_dest(f_dest), .ent_value(f_value), .src_reg(lu_reg[p]),
            .busy(lu_busy[p]), .ready(lu_ready[p]), .tag(lu_tag[p]), .value(lu_value[p])
        );
    end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 4,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [TAG_W-1:0] disp_tag,
    input logic [CNT_W-1:0] count,
    input logic             rf_we,
    input logic             st_commit,
    input logic             redirect
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));                                          // R3
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !disp_ready);                        // R3
    AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready) |=> disp_tag == $past(disp_tag) + TAG_W'(1)); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, st_commit, redirect}));                         // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        redirect |=> count == '0);                                        // R7
    AST_NO_DISP_IN_FLUSH: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !disp_ready);                                        // R7
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .count(occ), .rf_we(rf_we), .st_commit(st_commit),
    .redirect(redirect)
);

// File: tb/rob_core_test.sv
module rob_core_test;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NLU    = 2;
    localparam int TAG_W  = 4;

    logic clk = 1'b0;
    logic rst;
    logic disp_valid;
    logic [1:0] disp_kind;
    logic [REG_W-1:0] disp_dest;
    logic disp_ready;
    logic [TAG_W-1:0] disp_tag;
    logic wb_valid;
    logic [TAG_W-1:0] wb_tag;
    logic [DATA_W-1:0] wb_value;
    logic wb_mispred;
    logic [NLU-1:0][REG_W-1:0] lu_reg;
    logic [NLU-1:0] lu_busy, lu_ready;
    logic [NLU-1:0][TAG_W-1:0] lu_tag;
    logic [NLU-1:0][DATA_W-1:0] lu_value;
    logic rf_we, st_commit, redirect;
    logic [REG_W-1:0] rf_waddr;
    logic [DATA_W-1:0] commit_data, redirect_pc;
    logic [TAG_W-1:0] commit_tag;

    int n_tests = 0;
    int n_fail  = 0;

    rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .LU_PORTS(NLU)) uut (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_kind(disp_kind),
        .disp_dest(disp_dest), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mispred(wb_mispred),
        .lu_reg(lu_reg), .lu_busy(lu_busy), .lu_ready(lu_ready), .lu_tag(lu_tag),
        .lu_value(lu_value), .rf_we(rf_we), .rf_waddr(rf_waddr), .commit_data(commit_data),
        .st_commit(st_commit), .commit_tag(commit_tag), .redirect(redirect),
        .redirect_pc(redirect_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic next();
        @(posedge clk);
        #1;
        disp_valid = 1'b0;
        wb_valid   = 1'b0;
        wb_mispred = 1'b0;
    endtask

    task automatic dispatch(logic [1:0] kind, int dest, int exp_tag, string req);
        disp_valid = 1'b1;
        disp_kind  = kind;
        disp_dest  = REG_W'(dest);
        #1;
        chk(req, "disp_ready", 64'(disp_ready), 64'd1);
        chk(req, "disp_tag", 64'(disp_tag), 64'(exp_tag));
        next();
    endtask

    task automatic writeback(int tag, int val, logic mis);
        wb_valid   = 1'b1;
        wb_tag     = TAG_W'(tag);
        wb_value   = DATA_W'(val);
        wb_mispred = mis;
        next();
    endtask

    task automatic look(int r, logic eb, logic er, int et, int ev, string req);
        lu_reg[0] = REG_W'(r);
        #1;
        chk(req, "lu_busy", 64'(lu_busy[0]), 64'(eb));
        if (eb) begin
            chk(req, "lu_ready", 64'(lu_ready[0]), 64'(er));
            if (er) chk(req, "lu_value", 64'(lu_value[0]), 64'(ev));
            else    chk(req, "lu_tag", 64'(lu_tag[0]), 64'(et));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; disp_valid = 1'b0; disp_kind = 2'd0; disp_dest = '0;
        wb_valid = 1'b0; wb_tag = '0; wb_value = '0; wb_mispred = 1'b0;
        lu_reg = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "disp_ready", 64'(disp_ready), 64'd1);
        chk("R1", "disp_tag", 64'(disp_tag), 64'd0);
        chk("R1", "lu_busy", 64'(lu_busy), 64'd0);
        chk("R1", "strobes", 64'({rf_we, st_commit, redirect}), 64'd0);

        // R2 tags in order, R3 fill to full
        for (int i = 0; i < DEPTH; i++) dispatch(2'd0, i, i, "R2");
        #1 chk("R3", "disp_ready when full", 64'(disp_ready), 64'd0);
        disp_valid = 1'b1; disp_kind = 2'd0; disp_dest = 5'd31;
        next();
        look(31, 0, 0, 0, 0, "R3");
        look(5, 1, 0, 5, 0, "R8");

        // R4 reverse-order completion: head blocks
        for (int t = DEPTH - 1; t >= 1; t--) begin
            writeback(t, 100 + t, 1'b0);
            chk("R4", "rf_we behind incomplete head", 64'(rf_we), 64'd0);
        end
        look(7, 1, 1, 7, 107, "R8");
        writeback(0, 100, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R5", "rf_we", 64'(rf_we), 64'd1);
            chk("R5", "rf_waddr", 64'(rf_waddr), 64'(i));
            chk("R5", "commit_data", 64'(commit_data), 64'(100 + i));
            chk("R4", "commit_tag order", 64'(commit_tag), 64'(i));
            next();
        end
        chk("R5", "rf_we after drain", 64'(rf_we), 64'd0);
        look(3, 0, 0, 0, 0, "R5");
        chk("R2", "tag wrapped", 64'(disp_tag), 64'd0);

        // R8 youngest producer, store is not a producer
        dispatch(2'd0, 9, 0, "R2");
        dispatch(2'd0, 9, 1, "R2");
        dispatch(2'd0, 9, 2, "R2");
        dispatch(2'd1, 9, 3, "R2");
        for (int r = 0; r < 32; r++) begin
            lu_reg[0] = REG_W'(r);
            lu_reg[1] = REG_W'(31 - r);
            #1;
            chk("R8", "sweep port0 busy", 64'(lu_busy[0]), 64'(r == 9));
            chk("R8", "sweep port1 busy", 64'(lu_busy[1]), 64'((31 - r) == 9));
        end
        look(9, 1, 0, 2, 0, "R8");
        writeback(2, 55, 1'b0);
        look(9, 1, 1, 2, 55, "R8");
        writeback(1, 2, 1'b0);
        look(9, 1, 1, 2, 55, "R8");
        writeback(3, 77, 1'b0);
        writeback(0, 1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk("R5", "rf_we", 64'(rf_we), 64'd1);
            chk("R5", "rf_waddr", 64'(rf_waddr), 64'd9);
            chk("R5", "commit_data", 64'(commit_data), (i == 2) ? 64'd55 : 64'(i + 1));
            next();
        end
        chk("R6", "st_commit", 64'(st_commit), 64'd1);
        chk("R6", "rf_we on store", 64'(rf_we), 64'd0);
        chk("R6", "store data", 64'(commit_data), 64'd77);
        next();

        // R6 correctly predicted branch
        dispatch(2'd2, 0, 4, "R2");
        writeback(4, 32'h40, 1'b0);
        chk("R6", "branch strobes", 64'({rf_we, st_commit, redirect}), 64'd0);
        next();

        // R7 / R9 mispredicted branch flush
        dispatch(2'd2, 0, 5, "R2");
        dispatch(2'd0, 3, 6, "R2");
        dispatch(2'd0, 4, 7, "R2");
        writeback(7, 9, 1'b0);
        writeback(5, 32'h1234, 1'b1);
        disp_valid = 1'b1; disp_kind = 2'd0; disp_dest = 5'd20;
        wb_valid = 1'b1; wb_tag = 4'd6; wb_value = 32'd66;
        #1;
        chk("R7", "redirect", 64'(redirect), 64'd1);
        chk("R7", "redirect_pc", 64'(redirect_pc), 64'h1234);
        chk("R7", "disp_ready in flush", 64'(disp_ready), 64'd0);
        chk("R7", "rf_we in flush", 64'(rf_we), 64'd0);
        next();
        chk("R7", "redirect after", 64'(redirect), 64'd0);
        look(3, 0, 0, 0, 0, "R7");
        look(4, 0, 0, 0, 0, "R7");
        look(20, 0, 0, 0, 0, "R7");
        chk("R7", "next tag", 64'(disp_tag), 64'd6);
        dispatch(2'd0, 3, 6, "R9");
        look(3, 1, 0, 6, 0, "R9");
        writeback(6, 5, 1'b0);
        chk("R9", "rf_we", 64'(rf_we), 64'd1);
        chk("R9", "rf_waddr", 64'(rf_waddr), 64'd3);
        chk("R9", "commit_data", 64'(commit_data), 64'd5);
        next();
        writeback(6, 99, 1'b0);
        look(3, 0, 0, 0, 0, "R9");
        chk("R9", "rf_we after late wb", 64'(rf_we), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule